// File: doc/BRIEF.md
# Flag-Driven Non-Restoring Division Step Unit

This block carries out binary division one quotient bit per command. The whole division state sits in three status bits, Q, M and T, next to a partial-remainder register, a divisor register and a quotient register. A setup command prepares the flags for an unsigned or a signed divide. Each step command shifts the partial remainder left by one, feeds T in as its new bit 0, and then adds or subtracts the divisor. Which of the two it does depends on Q and M. The new quotient bit is left in T.

Software-style driving is done through a command port that accepts one command per cycle when the unit is idle. The results of a command show on the outputs in the next cycle. A built-in sequencer runs a full unsigned 64/32 divide: a start pulse loads the operands, the sequencer issues an unsigned setup, then 32 pairs of rotate-through-T and step, then one final rotate. At the end the quotient register holds the quotient. There is no special handling for a zero divisor.

States of the sequencer: IDLE (waits for start, accepts commands), SETUP (issues the unsigned setup), ROT (rotates T into the quotient register), STEP (issues one division step; after the 32nd it moves on, otherwise back to ROT), LAST (final rotate) and DONE (one-cycle completion pulse, then back to IDLE). Transitions: IDLE→SETUP on start, SETUP→ROT, ROT→STEP, STEP→ROT or STEP→LAST after the last step, LAST→DONE, DONE→IDLE.

Top module: `nrdiv_unit`

## Requirements
- R1: After reset, Q, M and T are 0, the remainder, quotient and divisor registers are 0, and busy and done are low.
- R2: The command op encodings are: 0 no operation, 1 load, 2 unsigned setup, 3 signed setup, 4 step, 5 rotate; codes 6 and 7 change nothing. Load copies arg_hi into the remainder register, arg_lo into the quotient register and arg_div into the divisor register.
- R3: Unsigned setup (op 2) clears Q, M and T.
- R4: Signed setup (op 3) sets Q to remainder bit 31 and M to divisor bit 31, and sets T to Q XOR M.
- R5: A step (op 4) shifts the remainder left by one with the old T as the new bit 0. It then subtracts the divisor when the old Q equals M, and adds it otherwise.
- R6: After a step, Q is the bit shifted out of the remainder (inverted when M is 1), XORed with the borrow of a subtract or the carry of an add.
- R7: After a step, T is 1 exactly when Q equals M, and M keeps its value.
- R8: Rotate (op 5) shifts the quotient register left by one with the old T in bit 0, and T takes the old quotient bit 31.
- R9: A start pulse in IDLE runs a full unsigned divide. When arg_hi is less than arg_div, the quotient output then equals the 64-bit dividend {arg_hi, arg_lo} divided by arg_div.
- R10: done is high for exactly one cycle, 66 clock cycles after the edge that samples start. This count is the same for a zero divisor, which gets no special handling.
- R11: While busy, command inputs and start have no effect on the running divide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Load operands and run a full unsigned divide |
| cmd_valid | input | 1 | Direct command present |
| cmd_op | input | 3 | Direct command code |
| arg_hi | input | 32 | Remainder / high dividend word for load |
| arg_lo | input | 32 | Quotient / low dividend word for load |
| arg_div | input | 32 | Divisor for load |
| busy | output | 1 | Sequencer running |
| done | output | 1 | One-cycle completion pulse |
| flag_q | output | 1 | Q flag |
| flag_m | output | 1 | M flag |
| flag_t | output | 1 | T flag |
| rem_out | output | 32 | Partial remainder register |
| quo_out | output | 32 | Quotient register |

## Verification
The hardest cases to reach are the two inverted-Q paths of the step, where M is 1. The unsigned sequencer never sets M, so these paths can only be reached through a signed setup with a negative divisor. The bench uses the direct command port to load chosen values, then issues a signed setup and a single step. The operands are picked by hand so that the add produces a carry while M is 1. A second hard case is a command arriving in the middle of a sequenced divide. The bench drives loads and start pulses during busy and then checks that the final quotient is still correct.

// File: rtl/nrdiv_pkg.sv
package nrdiv_pkg;
    typedef enum logic [2:0] {
        OP_NOP  = 3'd0,
        OP_LOAD = 3'd1,
        OP_SETU = 3'd2,
        OP_SETS = 3'd3,
        OP_STEP = 3'd4,
        OP_ROTC = 3'd5
    } div_op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SETUP,
        S_ROT,
        S_STEP,
        S_LAST,
        S_DONE
    } seq_state_e;
endpackage

// File: rtl/nrdiv_step_alu.sv
module nrdiv_step_alu #(
    parameter int W = 32
) (
    input  logic [W-1:0] rn,
    input  logic [W-1:0] rm,
    input  logic         q_in,
    input  logic         m_in,
    input  logic         t_in,
    output logic [W-1:0] rn_next,
    output logic         q_next,
    output logic         t_next
);
    logic [W-1:0] shifted;
    logic [W-1:0] diff;
    logic [W-1:0] sum;
    logic         do_sub;
    logic         wrap;
    logic         out_bit;

    always_comb begin
        shifted = {rn[W-2:0], t_in};
        diff    = shifted - rm;
        sum     = shifted + rm;
        do_sub  = (q_in == m_in);
        rn_next = do_sub ? diff : sum;
        wrap    = do_sub ? (diff > shifted) : (sum < shifted);
        out_bit = m_in ? ~rn[W-1] : rn[W-1];
        q_next  = out_bit ^ wrap;
        t_next  = (q_next == m_in);
    end
endmodule

// File: rtl/nrdiv_seq_fsm.sv
module nrdiv_seq_fsm
    import nrdiv_pkg::*;
#(
    parameter int STEPS = 32
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    start,
    output div_op_e seq_op,
    output logic    busy,
    output logic    done
);
    localparam int CW = (STEPS > 1) ? $clog2(STEPS) : 1;

    seq_state_e      state;
    seq_state_e      state_nx;
    logic [CW-1:0]   cnt;
    logic            last_step;

    assign last_step = (cnt == CW'(STEPS - 1));

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:  if (start) state_nx = S_SETUP;
            S_SETUP: state_nx = S_ROT;
            S_ROT:   state_nx = S_STEP;
            S_STEP:  state_nx = last_step ? S_LAST : S_ROT;
            S_LAST:  state_nx = S_DONE;
            S_DONE:  state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            if (state == S_SETUP)
                cnt <= '0;
            else if (state == S_STEP && !last_step)
                cnt <= cnt + 1'b1;
        end
    end

    always_comb begin
        seq_op = OP_NOP;
        busy   = 1'b1;
        done   = 1'b0;
        unique case (state)
            S_IDLE:  begin busy = 1'b0; if (start) seq_op = OP_LOAD; end
            S_SETUP: seq_op = OP_SETU;
            S_ROT:   seq_op = OP_ROTC;
            S_STEP:  seq_op = OP_STEP;
            S_LAST:  seq_op = OP_ROTC;
            S_DONE:  done = 1'b1;
            default: busy = 1'b0;
        endcase
    end

    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r10_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_op == OP_ROTC && state == S_LAST) |=> done);
endmodule

// File: rtl/nrdiv_unit.sv
module nrdiv_unit
    import nrdiv_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         cmd_valid,
    input  logic [2:0]   cmd_op,
    input  logic [W-1:0] arg_hi,
    input  logic [W-1:0] arg_lo,
    input  logic [W-1:0] arg_div,
    output logic         busy,
    output logic         done,
    output logic         flag_q,
    output logic         flag_m,
    output logic         flag_t,
    output logic [W-1:0] rem_out,
    output logic [W-1:0] quo_out
);
    div_op_e      seq_op;
    div_op_e      eff_op;
    logic [W-1:0] rem_r, quo_r, dvs_r;
    logic         q_r, m_r, t_r;
    logic [W-1:0] alu_rn;
    logic         alu_q, alu_t;

    nrdiv_seq_fsm #(.STEPS(W)) u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .seq_op (seq_op),
        .busy   (busy),
        .done   (done)
    );

    nrdiv_step_alu #(.W(W)) u_alu (
        .rn      (rem_r),
        .rm      (dvs_r),
        .q_in    (q_r),
        .m_in    (m_r),
        .t_in    (t_r),
        .rn_next (alu_rn),
        .q_next  (alu_q),
        .t_next  (alu_t)
    );

    always_comb begin
        eff_op = OP_NOP;
        if (seq_op != OP_NOP)
            eff_op = seq_op;
        else if (!busy && cmd_valid && cmd_op <= 3'd5)
            eff_op = div_op_e'(cmd_op);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_r <= '0;
            quo_r <= '0;
            dvs_r <= '0;
            q_r   <= 1'b0;
            m_r   <= 1'b0;
            t_r   <= 1'b0;
        end else begin
            unique case (eff_op)
                OP_LOAD: begin
                    rem_r <= arg_hi;
                    quo_r <= arg_lo;
                    dvs_r <= arg_div;
                end
                OP_SETU: begin
                    q_r <= 1'b0;
                    m_r <= 1'b0;
                    t_r <= 1'b0;
                end
                OP_SETS: begin
                    q_r <= rem_r[W-1];
                    m_r <= dvs_r[W-1];
                    t_r <= rem_r[W-1] ^ dvs_r[W-1];
                end
                OP_STEP: begin
                    rem_r <= alu_rn;
                    q_r   <= alu_q;
                    t_r   <= alu_t;
                end
                OP_ROTC: begin
                    quo_r <= {quo_r[W-2:0], t_r};
                    t_r   <= quo_r[W-1];
                end
                default: ;
            endcase
        end
    end

    assign flag_q  = q_r;
    assign flag_m  = m_r;
    assign flag_t  = t_r;
    assign rem_out = rem_r;
    assign quo_out = quo_r;

    a_r3_setu_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (eff_op == OP_SETU) |=> (!flag_q && !flag_m && !flag_t));
    a_r4_sets_loads: assert property (@(posedge clk) disable iff (!rst_n)
        (eff_op == OP_SETS) |=> (flag_q == $past(rem_r[W-1]) && flag_t == (flag_q ^ flag_m)));
    a_r7_step_t_matches: assert property (@(posedge clk) disable iff (!rst_n)
        (eff_op == OP_STEP) |=> (flag_t == (flag_q == flag_m)));
    a_r7_step_keeps_m: assert property (@(posedge clk) disable iff (!rst_n)
        (eff_op == OP_STEP) |=> $stable(flag_m));
    a_r11_busy_holds_divisor: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(dvs_r));
endmodule

// File: tb/nrdiv_unit_bench.sv
module nrdiv_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = 3'd0;
    logic [31:0] arg_hi = '0, arg_lo = '0, arg_div = '0;
    logic        busy, done, flag_q, flag_m, flag_t;
    logic [31:0] rem_out, quo_out;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    nrdiv_unit u_nrdiv_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd_valid(cmd_valid),
        .cmd_op(cmd_op), .arg_hi(arg_hi), .arg_lo(arg_lo), .arg_div(arg_div),
        .busy(busy), .done(done), .flag_q(flag_q), .flag_m(flag_m),
        .flag_t(flag_t), .rem_out(rem_out), .quo_out(quo_out)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cmd(input logic [2:0] op, input logic [31:0] hi, input logic [31:0] lo,
                       input logic [31:0] dv);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; arg_hi = hi; arg_lo = lo; arg_div = dv;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 3'd0;
    endtask

    task automatic run_divide(input string req, input logic [31:0] hi, input logic [31:0] lo,
                              input logic [31:0] dv, input bit disturb, input bit check_q);
        int cyc = 0;
        logic [63:0] expq;
        @(negedge clk);
        start = 1'b1; arg_hi = hi; arg_lo = lo; arg_div = dv;
        @(negedge clk);
        start = 1'b0;
        while (!done && cyc < 200) begin
            if (disturb && cyc >= 5 && cyc < 9) begin
                start = 1'b1; cmd_valid = 1'b1; cmd_op = 3'd1;
                arg_hi = 32'hDEAD_BEEF; arg_lo = 32'h0; arg_div = 32'h3;
            end else begin
                start = 1'b0; cmd_valid = 1'b0; cmd_op = 3'd0;
            end
            @(negedge clk);
            cyc++;
        end
        start = 1'b0; cmd_valid = 1'b0;
        check({req, " cycles to done"}, 64'(cyc), 64'd66);
        if (check_q) begin
            expq = {hi, lo} / {32'h0, dv};
            check({req, " quotient"}, {32'h0, quo_out}, expq);
        end
        @(negedge clk);
        check({req, " done one cycle"}, {63'h0, done}, 64'h0);
    endtask

    task automatic t_reset;
        check("R1 flags", {61'h0, flag_q, flag_m, flag_t}, 64'h0);
        check("R1 regs", {rem_out, quo_out}, 64'h0);
        check("R1 busy/done", {62'h0, busy, done}, 64'h0);
    endtask

    task automatic t_unsigned_step;
        cmd(3'd1, 32'h8000_0001, 32'h0, 32'h3);
        check("R2 load", {rem_out, quo_out}, {32'h8000_0001, 32'h0});
        cmd(3'd2, 0, 0, 0);
        check("R3 setu", {61'h0, flag_q, flag_m, flag_t}, 64'h0);
        cmd(3'd4, 0, 0, 0);
        check("R5 step sub", {32'h0, rem_out}, 64'hFFFF_FFFF);
        check("R6 q borrow", {63'h0, flag_q}, 64'h0);
        check("R7 t/m", {62'h0, flag_m, flag_t}, 64'h1);
    endtask

    task automatic t_signed_steps;
        cmd(3'd1, 32'h8000_0000, 32'h0, 32'h5);
        cmd(3'd3, 0, 0, 0);
        check("R4 sets pos div", {61'h0, flag_q, flag_m, flag_t}, 64'h5);
        cmd(3'd4, 0, 0, 0);
        check("R5 step add", {32'h0, rem_out}, 64'h6);
        check("R6 R7 flags", {61'h0, flag_q, flag_m, flag_t}, 64'h4);
        cmd(3'd1, 32'h0000_0010, 32'h0, 32'hFFFF_FFFE);
        cmd(3'd3, 0, 0, 0);
        check("R4 sets neg div", {61'h0, flag_q, flag_m, flag_t}, 64'h3);
        cmd(3'd4, 0, 0, 0);
        check("R5 add carry", {32'h0, rem_out}, 64'h1F);
        check("R6 inverted q", {61'h0, flag_q, flag_m, flag_t}, 64'h2);
    endtask

    task automatic t_rotate;
        cmd(3'd1, 32'h0, 32'h8000_0001, 32'h1);
        cmd(3'd2, 0, 0, 0);
        cmd(3'd5, 0, 0, 0);
        check("R8 rotate 1", {31'h0, flag_t, quo_out}, {31'h0, 1'b1, 32'h2});
        cmd(3'd5, 0, 0, 0);
        check("R8 rotate 2", {31'h0, flag_t, quo_out}, {31'h0, 1'b0, 32'h5});
        cmd(3'd7, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        cmd(3'd6, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        check("R2 unused codes", {rem_out, quo_out}, {32'h0, 32'h5});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_unsigned_step();
        t_signed_steps();
        t_rotate();
        run_divide("R9 small", 32'h0, 32'd100, 32'd7, 0, 1);
        run_divide("R9 wide", 32'h3, 32'h1234_5678, 32'h10, 0, 1);
        run_divide("R9 max", 32'h7FFF_FFFF, 32'hFFFF_FFFF, 32'h8000_0000, 0, 1);
        run_divide("R9 unit div", 32'h0, 32'hCAFE_F00D, 32'h1, 0, 1);
        run_divide("R11 busy ignore", 32'h1, 32'h0, 32'h3, 1, 1);
        run_divide("R10 zero div", 32'h0, 32'h5, 32'h0, 0, 0);
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule